// File: doc/BRIEF.md
# Serial Position Shift-Out Register

This block sends a parallel position word, normally a 16-bit Gray code, to an external receiver over a serial line. The receiver drives a serial clock and a load/shift select. While load is selected, the register keeps copying the parallel word on every system clock cycle, and the serial output shows the word's top bit. Once shift is selected, each serial clock edge moves the register one place toward the output. The most significant bit leaves first, and a cascade input is taken in at the bottom end.

The cascade input lets several encoders be chained, with the output of one feeding the input of the next. It can also be tied to the block's own output, so the word recirculates as a ring. A direction input flips only the top bit of the loaded word, which reverses the counting direction of the code.

The serial clock, the load/shift select and the cascade input come from outside the chip. They pass through a synchronizer of equal depth into the system clock domain, so the cascade bit is captured as it stood at the serial clock edge. This holds even if an upstream device changes it shortly after that edge.

Top module: `pos_shift_out`

## Requirements
- R1: After reset the serial output `sdo_o` is 0 and the block is in shift mode.
- R2: While `load_i` = 1, the register follows `pos_i` on every system clock, and `sdo_o` shows the loaded top bit within 3 system clocks of a change. The word in the register when `load_i` falls is the one sent.
- R3: With `msb_inv_i` = 1 the top bit (bit WIDTH-1) of the loaded word is inverted. All other bits are loaded unchanged. With 0 the word is loaded as is.
- R4: With `load_i` = 0, each rising edge of `sclk_i` advances the register by one bit, most significant bit first. After edge n (1 ≤ n < WIDTH), `sdo_o` shows loaded bit WIDTH-1-n.
- R5: On each shift, `sdi_i` enters at bit 0. After WIDTH edges, `sdo_o` shows the `sdi_i` value taken at the first edge, and later edges keep delivering cascade bits in order.
- R6: With `sdi_i` tied to `sdo_o`, the loaded word reappears on `sdo_o` after every WIDTH edges (ring mode).
- R7: In shift mode, changes on `pos_i` and `msb_inv_i` have no effect on `sdo_o`.
- R8: Falling edges of `sclk_i` do not shift, and `sdo_o` is constant throughout the low phase of `sclk_i`.
- R9: With two synchronizer stages, `sdo_o` still holds the old bit 1 system clock after `sclk_i` rises and shows the new bit 3 system clocks after it rises.
- R10: The `sdi_i` bit shifted in is the value present at the `sclk_i` rising edge, even if `sdi_i` changes one system clock after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the receiver (asynchronous) |
| load_i | input | 1 | 1 = load mode, 0 = shift mode (asynchronous) |
| sdi_i | input | 1 | Cascade / ring serial input (asynchronous) |
| msb_inv_i | input | 1 | 1 = invert top bit of loaded word |
| pos_i | input | WIDTH | Parallel position word |
| sdo_o | output | 1 | Serial data output, MSB first |

## Verification
The bench changes `sdi_i` one system clock after each serial clock rise. If the cascade path were synchronized more shallowly than the clock, a later bit would be captured and the chained word would come out corrupted. The bench keeps clocking past the word length to check that cascade bits emerge after exactly WIDTH edges, and an off-by-one shift count would show the wrong bit there. It also runs ring mode for two full rotations, which shows up any bit lost or duplicated at the wrap. Other tests cover inversion hitting the wrong bit, a shift on the falling edge (the output would move during the low phase), and a parallel word that leaks through in shift mode.

// File: rtl/pos_shift_pkg.sv
package pos_shift_pkg;

   typedef enum logic {
      MODE_SHIFT = 1'b0,
      MODE_LOAD  = 1'b1
   } xfer_mode_e;

   // bit positions in the synchronized input bundle
   localparam int unsigned SIG_SCLK = 0;
   localparam int unsigned SIG_LOAD = 1;
   localparam int unsigned SIG_DIN  = 2;
   localparam int unsigned NUM_SIG  = 3;

endpackage

// File: rtl/pos_shift_sync.sv
module pos_shift_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned NSIG   = 3,
   parameter bit          RISE   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSIG-1:0] d_i,
   output logic [NSIG-1:0] lvl_o,
   output logic            edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pos_shift_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][NSIG-1:0] stg;
   logic                        prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg  <= '0;
         prev <= 1'b0;
      end else begin
         stg  <= {stg[STAGES-2:0], d_i};
         prev <= stg[STAGES-1][0];
      end
   end

   assign lvl_o = stg[STAGES-1];

   if (RISE) begin : g_rise
      assign edge_o = lvl_o[0] & ~prev;
   end else begin : g_fall
      assign edge_o = ~lvl_o[0] & prev;
   end

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

endmodule

// File: rtl/pos_shift_reg.sv
module pos_shift_reg
   import pos_shift_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xfer_mode_e       mode_i,
   input  logic             shift_i,
   input  logic             din_i,
   input  logic [WIDTH-1:0] word_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("pos_shift_reg: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (mode_i == MODE_LOAD) begin
         q_o <= word_i;
      end else if (shift_i) begin
         q_o <= {q_o[WIDTH-2:0], din_i};
      end
   end

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_LOAD) |=> q_o == $past(word_i));

   // R5
   shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_SHIFT && shift_i) |=> q_o[0] == $past(din_i));

   // R4
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_SHIFT && shift_i) |=> q_o[WIDTH-1:1] == $past(q_o[WIDTH-2:0]));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_SHIFT && !shift_i) |=> $stable(q_o));

endmodule

// File: rtl/pos_shift_out.sv
module pos_shift_out
   import pos_shift_pkg::*;
#(
   parameter int unsigned WIDTH         = 16,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          SHIFT_ON_RISE = 1'b1,
   parameter bit          DIR_INV_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_i,
   input  logic             load_i,
   input  logic             sdi_i,
   input  logic             msb_inv_i,
   input  logic [WIDTH-1:0] pos_i,
   output logic             sdo_o
);

   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("pos_shift_out: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pos_shift_out: SYNC_STAGES must be at least 2");
   end

   logic [NUM_SIG-1:0] raw_in;
   logic [NUM_SIG-1:0] sync_lvl;
   logic               shift_pulse;
   logic [WIDTH-1:0]   load_word;
   logic [WIDTH-1:0]   shreg;
   xfer_mode_e         mode;

   always_comb begin
      raw_in           = '0;
      raw_in[SIG_SCLK] = sclk_i;
      raw_in[SIG_LOAD] = load_i;
      raw_in[SIG_DIN]  = sdi_i;
   end

   pos_shift_sync #(
      .STAGES (SYNC_STAGES),
      .NSIG   (NUM_SIG),
      .RISE   (SHIFT_ON_RISE)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw_in),
      .lvl_o  (sync_lvl),
      .edge_o (shift_pulse)
   );

   assign mode = sync_lvl[SIG_LOAD] ? MODE_LOAD : MODE_SHIFT;

   if (DIR_INV_EN) begin : g_dir_inv
      assign load_word = {pos_i[TOP] ^ msb_inv_i, pos_i[TOP-1:0]};
   end else begin : g_dir_fixed
      assign load_word = pos_i;
   end

   pos_shift_reg #(
      .WIDTH (WIDTH)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode),
      .shift_i (shift_pulse),
      .din_i   (sync_lvl[SIG_DIN]),
      .word_i  (load_word),
      .q_o     (shreg)
   );

   assign sdo_o = shreg[TOP];

   // R1
   reset_out_chk: assert property (@(posedge clk)
      !rst_n |=> (sdo_o == 1'b0) || rst_n);

   // R3
   dir_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LOAD) |=> shreg[TOP-1:0] == $past(pos_i[TOP-1:0]));

endmodule

// File: tb/pos_shift_out_tb.sv
module pos_shift_out_tb;

   localparam int W          = 16;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0;
   logic         load = 1'b0;
   logic         sdi_drv = 1'b0;
   logic         ring = 1'b0;
   logic         msb_inv = 1'b0;
   logic [W-1:0] pos = '0;
   logic         sdo;
   logic         sdi_w;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit model[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sdi_w = ring ? sdo : sdi_drv;

   pos_shift_out #(.WIDTH(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .load_i    (load),
      .sdi_i     (sdi_w),
      .msb_inv_i (msb_inv),
      .pos_i     (pos),
      .sdo_o     (sdo)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: sdo actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_load(input logic [W-1:0] word, input logic inv);
      @(negedge clk);
      load = 1'b1; pos = word; msb_inv = inv;
      repeat (5) @(negedge clk);
      chk(sdo, word[W-1] ^ inv, inv ? "R3" : "R2");
      model.delete();
      model.push_back(word[W-1] ^ inv);
      for (int i = W - 2; i >= 0; i--) model.push_back(word[i]);
      load = 1'b0;
      repeat (5) @(negedge clk);
      chk(sdo, model[0], "R2");
   endtask

   task automatic pulse(input logic din, input bit perturb, input bit scramble, input string req);
      logic old;
      logic cap;
      sdi_drv = din;
      @(negedge clk);
      sclk = 1'b1;
      old  = model[0];
      cap  = ring ? old : din;
      model.push_back(cap);
      void'(model.pop_front());
      for (int c = 1; c < HALF; c++) begin
         @(negedge clk);
         if (c == 1) begin
            chk(sdo, old, "R9");
            if (perturb) sdi_drv = ~din;
         end
         if (c == 2 && scramble) begin
            pos = $urandom; msb_inv = $urandom;
         end
         if (c == 3) chk(sdo, model[0], "R9");
         if (c > 3) chk(sdo, model[0], req);
      end
      @(negedge clk);
      sclk = 1'b0;
      for (int c = 0; c < HALF; c++) begin
         @(negedge clk);
         chk(sdo, model[0], "R8");
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] w;
      logic first_in;
      repeat (4) @(negedge clk);
      chk(sdo, 1'b0, "R1");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sdo, 1'b0, "R1");

      // R4 R5 R10: word out MSB first, cascade bits follow, sdi moves after edge
      for (int t = 0; t < 4; t++) begin
         w = $urandom;
         do_load(w, t[0]);
         first_in = $urandom;
         for (int k = 0; k < W; k++) begin
            logic b;
            b = (k == 0) ? first_in : logic'($urandom);
            pulse(b, 1'b1, t[1], (k == 0) ? "R10" : "R4");
         end
         chk(sdo, first_in, "R5");
         for (int k = 0; k < 3; k++) pulse(logic'($urandom), 1'b1, 1'b1, "R5");
      end

      // R3: inversion touches only the top bit
      w = 16'h0001;
      do_load(w, 1'b1);
      for (int k = 0; k < W - 1; k++) pulse(1'b0, 1'b0, 1'b0, "R3");
      chk(sdo, 1'b1, "R3");

      // R2: continuous capture while load held, sclk toggling
      @(negedge clk);
      load = 1'b1; msb_inv = 1'b0;
      for (int k = 0; k < 6; k++) begin
         pos = $urandom;
         sclk = ~sclk;
         repeat (4) @(negedge clk);
         chk(sdo, pos[W-1], "R2");
      end
      sclk = 1'b0;
      load = 1'b0;
      model.delete();
      for (int i = W - 1; i >= 0; i--) model.push_back(pos[i]);
      repeat (5) @(negedge clk);
      chk(sdo, model[0], "R2");

      // R6: ring mode, two rotations
      w = $urandom;
      do_load(w, 1'b0);
      ring = 1'b1;
      for (int k = 0; k < 2 * W; k++) pulse(1'b0, 1'b0, 1'b1, "R6");
      chk(sdo, w[W-1], "R6");
      ring = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule